// File: doc/BRIEF.md
# Speculative Two-Stage Crossbar Switch Allocator

This block decides, once per clock, which buffered flits cross a virtual-channel router's crossbar. The router has P ports and V virtual channels (VCs) on each input. Two separable allocators run side by side on the same inputs. Each one first reduces the requesting VCs of every input port to a single candidate with a V:1 round-robin arbiter. It then lets every output port choose one of the candidate inputs aimed at it with a P:1 round-robin arbiter. The matching this produces is not guaranteed to be maximal.

The first allocator takes non-speculative requests. These come from VCs that already hold a downstream VC. The second takes speculative requests. These come from VCs that are being through VC allocation in this same cycle and assume that VC allocation will succeed. In the same cycle the VC allocator reports which VCs did succeed. A speculative win for a VC that failed is dropped, and its crossbar slot stays idle for that cycle. Non-speculative grants always outrank speculative ones, at the input side and at the output side. The grants are combinational from the requests, so a flit can be switched in the cycle its request appears. Only the round-robin pointers are registers.

Top module: `spec_sw_alloc`

## Requirements
- R1: After reset, and in any cycle without requests, `xbar_vld` and `deq_gnt` are all zero.
- R2: In every cycle at most one VC per input port is granted, and each granted VC drives exactly one output port.
- R3: A lone non-speculative request from VC v of input i to output o, with credit at o, is granted in the same cycle. `deq_gnt[i*V+v]` is 1, `xbar_vld[o]` is 1 and `xbar_sel[o*PW +: PW]` equals i. Target port codes are PW-bit fields at `(i*V+v)*PW`, and codes of P or more are never driven.
- R4: At each input the VC stage is round-robin. Priority starts at the pointer and rises in index order with wrap. A used grant moves the pointer to the winner plus one.
- R5: At each output the input stage is round-robin in the same way, over input port indices.
- R6: A request to an output whose `credit_ok` bit is 0 is removed before both stages. It cannot block another VC of the same input, and that output stays invalid.
- R7: A speculative grant survives only if `va_ok` is 1 for the winning VC in the same cycle. If it fails, that output and that input carry no speculative grant in the cycle, even when another speculative request could have used them.
- R8: A speculative grant is dropped when its input port or its output port already holds a non-speculative grant in the same cycle.
- R9: A round-robin pointer moves only when its grant is actually used. A speculative winner that is cancelled keeps its priority for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all pointers |
| ns_req | input | P*V | Non-speculative request per input VC, bit i*V+v |
| ns_port | input | P*V*PW | Target output of each non-speculative request |
| sp_req | input | P*V | Speculative request per input VC |
| sp_port | input | P*V*PW | Target output of each speculative request |
| va_ok | input | P*V | Same-cycle VC-allocation success per input VC |
| credit_ok | input | P | Output port has downstream credit |
| xbar_vld | output | P | Output port carries a flit this cycle |
| xbar_sel | output | P*PW | Input index selected for each output port |
| deq_gnt | output | P*V | Dequeue grant per input VC |

## Verification
The bench builds the block with P=3 and V=2. At that size the pointers of all twelve arbiters wrap often, and the two-bit port fields include an unused code. A pseudo-random sweep of several thousand cycles therefore covers every mix of the two request kinds, credit masks and VC-allocation outcomes many times over. Every output bit is compared with an arithmetic model that the bench computes. Directed cycles after a fresh reset pin down priority between the two kinds, cancellation, credit masking and the way a pointer holds after a wasted slot, each with hand-derived values.

// File: rtl/swa_pkg.sv
package swa_pkg;

    // Which allocator drives an output port in the current cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NS   = 2'd1,
        SRC_SP   = 2'd2
    } xsrc_e;

    // Index width for a set of n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/swa_rr_arb.sv
module swa_rr_arb #(
    parameter  int N  = 2,
    localparam int IW = swa_pkg::idx_w(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [IW-1:0] ptr;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!any && req[j]) begin
                any = 1'b1;
                idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv && any)
            ptr <= (int'(idx) == N - 1) ? '0 : idx + IW'(1);
    end

    // R4 R5: after a used grant with several requesters, an unchanged request set picks someone else
    rotate_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && any && $countones(req) > 1) |=> !(req == $past(req) && idx == $past(idx)));

endmodule

// File: rtl/swa_sep_alloc.sv
module swa_sep_alloc #(
    parameter  int P  = 5,
    parameter  int V  = 2,
    localparam int PW = swa_pkg::idx_w(P),
    localparam int IW = swa_pkg::idx_w(V)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [P*V-1:0]         req,
    input  logic [P*V*PW-1:0]      port,
    input  logic [P-1:0]           credit,
    input  logic [P-1:0]           use_in,
    input  logic [P-1:0]           use_out,
    output logic [P-1:0][IW-1:0]   win_vc,
    output logic [P-1:0]           out_vld,
    output logic [P-1:0][PW-1:0]   out_in
);
    logic [P-1:0]         in_any;
    logic [P-1:0][PW-1:0] win_port;

    // Stage one: one VC per input port, credit-masked.
    for (genvar i = 0; i < P; i++) begin : g_in
        logic [V-1:0] r1;
        for (genvar v = 0; v < V; v++) begin : g_vc
            logic [PW-1:0] tgt;
            assign tgt   = port[(i*V+v)*PW +: PW];
            assign r1[v] = req[i*V+v] && (int'(tgt) < P) && credit[tgt];
        end
        swa_rr_arb #(.N(V)) u_vc_arb (
            .clk (clk),
            .rst (rst),
            .req (r1),
            .adv (use_in[i]),
            .idx (win_vc[i]),
            .any (in_any[i])
        );
        assign win_port[i] = port[(i*V + int'(win_vc[i]))*PW +: PW];
    end

    // Stage two: one input per output port.
    for (genvar o = 0; o < P; o++) begin : g_out
        logic [P-1:0] r2;
        for (genvar i = 0; i < P; i++) begin : g_src
            assign r2[i] = in_any[i] && (win_port[i] == PW'(o));
        end
        swa_rr_arb #(.N(P)) u_port_arb (
            .clk (clk),
            .rst (rst),
            .req (r2),
            .adv (use_out[o]),
            .idx (out_in[o]),
            .any (out_vld[o])
        );
    end

endmodule

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
    parameter  int P  = 5,
    parameter  int V  = 2,
    localparam int PW = swa_pkg::idx_w(P),
    localparam int IW = swa_pkg::idx_w(V)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [P*V-1:0]    ns_req,
    input  logic [P*V*PW-1:0] ns_port,
    input  logic [P*V-1:0]    sp_req,
    input  logic [P*V*PW-1:0] sp_port,
    input  logic [P*V-1:0]    va_ok,
    input  logic [P-1:0]      credit_ok,
    output logic [P-1:0]      xbar_vld,
    output logic [P*PW-1:0]   xbar_sel,
    output logic [P*V-1:0]    deq_gnt
);
    import swa_pkg::*;

    logic [P-1:0][IW-1:0] ns_win_vc, sp_win_vc;
    logic [P-1:0]         ns_out_vld, sp_out_vld;
    logic [P-1:0][PW-1:0] ns_out_in, sp_out_in;
    logic [P-1:0]         ns_in_used, sp_in_used, sp_keep;
    xsrc_e                out_src [P];

    swa_sep_alloc #(.P(P), .V(V)) u_ns (
        .clk     (clk),
        .rst     (rst),
        .req     (ns_req),
        .port    (ns_port),
        .credit  (credit_ok),
        .use_in  (ns_in_used),
        .use_out (ns_out_vld),
        .win_vc  (ns_win_vc),
        .out_vld (ns_out_vld),
        .out_in  (ns_out_in)
    );

    swa_sep_alloc #(.P(P), .V(V)) u_sp (
        .clk     (clk),
        .rst     (rst),
        .req     (sp_req),
        .port    (sp_port),
        .credit  (credit_ok),
        .use_in  (sp_in_used),
        .use_out (sp_keep),
        .win_vc  (sp_win_vc),
        .out_vld (sp_out_vld),
        .out_in  (sp_out_in)
    );

    // Inputs matched by the non-speculative allocator.
    always_comb begin
        ns_in_used = '0;
        for (int o = 0; o < P; o++)
            if (ns_out_vld[o]) ns_in_used[ns_out_in[o]] = 1'b1;
    end

    // Speculative survivors: no non-speculative claim on either side, VC allocation won.
    always_comb begin
        sp_in_used = '0;
        for (int o = 0; o < P; o++) begin
            sp_keep[o] = sp_out_vld[o] && !ns_out_vld[o] && !ns_in_used[sp_out_in[o]]
                      && va_ok[int'(sp_out_in[o])*V + int'(sp_win_vc[sp_out_in[o]])];
            if (sp_keep[o]) sp_in_used[sp_out_in[o]] = 1'b1;
        end
    end

    always_comb begin
        for (int o = 0; o < P; o++) begin
            if (ns_out_vld[o])   out_src[o] = SRC_NS;
            else if (sp_keep[o]) out_src[o] = SRC_SP;
            else                 out_src[o] = SRC_NONE;
            xbar_vld[o]           = (out_src[o] != SRC_NONE);
            xbar_sel[o*PW +: PW]  = (out_src[o] == SRC_SP) ? sp_out_in[o] : ns_out_in[o];
        end
        deq_gnt = '0;
        for (int i = 0; i < P; i++) begin
            if (ns_in_used[i])      deq_gnt[i*V + int'(ns_win_vc[i])] = 1'b1;
            else if (sp_in_used[i]) deq_gnt[i*V + int'(sp_win_vc[i])] = 1'b1;
        end
    end

    for (genvar i = 0; i < P; i++) begin : g_in_chk
        // R2
        one_vc_per_input_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(deq_gnt[i*V +: V]));
    end

    for (genvar o = 0; o < P; o++) begin : g_out_chk
        // R6
        credit_respect_chk: assert property (@(posedge clk) disable iff (rst)
            xbar_vld[o] |-> credit_ok[o]);
    end

    for (genvar k = 0; k < P*V; k++) begin : g_vc_chk
        // R3
        grant_has_req_chk: assert property (@(posedge clk) disable iff (rst)
            deq_gnt[k] |-> (ns_req[k] || sp_req[k]));
        // R7
        spec_needs_va_chk: assert property (@(posedge clk) disable iff (rst)
            (deq_gnt[k] && !ns_req[k]) |-> va_ok[k]);
    end

    // R2: number of connected outputs equals number of dequeued VCs
    match_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(xbar_vld) == $countones(deq_gnt));

endmodule

// File: tb/spec_sw_alloc_bench.sv
`timescale 1ns/1ps
module spec_sw_alloc_bench;
    localparam int P  = 3;
    localparam int V  = 2;
    localparam int PW = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [P*V-1:0]    ns_req = '0, sp_req = '0, va_ok = '0;
    logic [P*V*PW-1:0] ns_port = '0, sp_port = '0;
    logic [P-1:0]      credit_ok = '1;
    logic [P-1:0]      xbar_vld;
    logic [P*PW-1:0]   xbar_sel;
    logic [P*V-1:0]    deq_gnt;

    int n_chk = 0, n_bad = 0;

    // model state: kind 0 = non-speculative, 1 = speculative
    int m_pi [2][P];
    int m_po [2][P];
    int w    [2][P];
    int g    [2][P];
    bit nsin [P];
    bit spin [P];
    bit keep [P];
    logic [P-1:0]   e_vld;
    int             e_sel [P];
    logic [P*V-1:0] e_deq;

    spec_sw_alloc #(.P(P), .V(V)) u_spec_sw_alloc (
        .clk(clk), .rst(rst), .ns_req(ns_req), .ns_port(ns_port),
        .sp_req(sp_req), .sp_port(sp_port), .va_ok(va_ok),
        .credit_ok(credit_ok), .xbar_vld(xbar_vld), .xbar_sel(xbar_sel),
        .deq_gnt(deq_gnt)
    );

    always #2.5 clk = ~clk;

    function automatic int portof(input int kd, input int i, input int v);
        return kd == 1 ? int'(sp_port[(i*V+v)*PW +: PW]) : int'(ns_port[(i*V+v)*PW +: PW]);
    endfunction

    task automatic model_eval();
        for (int kd = 0; kd < 2; kd++) begin
            for (int i = 0; i < P; i++) begin
                w[kd][i] = -1;
                for (int k = 0; k < V; k++) begin
                    int v, pt;
                    bit r;
                    v  = (m_pi[kd][i] + k) % V;
                    r  = kd == 1 ? sp_req[i*V+v] : ns_req[i*V+v];
                    pt = portof(kd, i, v);
                    if (w[kd][i] < 0 && r && pt < P && credit_ok[pt]) w[kd][i] = v;
                end
            end
            for (int o = 0; o < P; o++) begin
                g[kd][o] = -1;
                for (int k = 0; k < P; k++) begin
                    int i;
                    i = (m_po[kd][o] + k) % P;
                    if (g[kd][o] < 0 && w[kd][i] >= 0 && portof(kd, i, w[kd][i]) == o) g[kd][o] = i;
                end
            end
        end
        for (int i = 0; i < P; i++) begin nsin[i] = 0; spin[i] = 0; end
        for (int o = 0; o < P; o++) if (g[0][o] >= 0) nsin[g[0][o]] = 1;
        e_deq = '0;
        for (int o = 0; o < P; o++) begin
            int i;
            i = g[1][o];
            keep[o] = (i >= 0) && (g[0][o] < 0) && !nsin[i] && va_ok[i*V + w[1][i]];
            if (keep[o]) spin[i] = 1;
            e_vld[o] = (g[0][o] >= 0) || keep[o];
            e_sel[o] = (g[0][o] >= 0) ? g[0][o] : g[1][o];
        end
        for (int i = 0; i < P; i++) begin
            if (nsin[i])      e_deq[i*V + w[0][i]] = 1'b1;
            else if (spin[i]) e_deq[i*V + w[1][i]] = 1'b1;
        end
    endtask

    task automatic model_adv();
        for (int i = 0; i < P; i++) begin
            if (nsin[i]) m_pi[0][i] = (w[0][i] + 1) % V;
            if (spin[i]) m_pi[1][i] = (w[1][i] + 1) % V;
        end
        for (int o = 0; o < P; o++) begin
            if (g[0][o] >= 0) m_po[0][o] = (g[0][o] + 1) % P;
            if (keep[o])      m_po[1][o] = (g[1][o] + 1) % P;
        end
    endtask

    task automatic model_clear();
        for (int kd = 0; kd < 2; kd++)
            for (int i = 0; i < P; i++) begin m_pi[kd][i] = 0; m_po[kd][i] = 0; end
    endtask

    // compare all outputs with the model, then advance the model pointers
    task automatic cmp_model(input string tag);
        bit ok;
        model_eval();
        ok = (xbar_vld === e_vld) && (deq_gnt === e_deq);
        for (int o = 0; o < P; o++)
            if (e_vld[o] && int'(xbar_sel[o*PW +: PW]) != e_sel[o]) ok = 0;
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: vld=%b sel=%b deq=%b expected vld=%b sel=%0d,%0d,%0d deq=%b",
                     tag, xbar_vld, xbar_sel, deq_gnt, e_vld, e_sel[0], e_sel[1], e_sel[2], e_deq);
        end
        model_adv();
    endtask

    task automatic hand(input string tag, input logic [P-1:0] ev, input logic [P*V-1:0] ed);
        n_chk++;
        if (xbar_vld !== ev || deq_gnt !== ed) begin
            n_bad++;
            $display("FAIL %s: vld=%b deq=%b expected vld=%b deq=%b", tag, xbar_vld, deq_gnt, ev, ed);
        end
    endtask

    task automatic hand_sel(input string tag, input int o, input int ei);
        n_chk++;
        if (int'(xbar_sel[o*PW +: PW]) != ei) begin
            n_bad++;
            $display("FAIL %s: sel[%0d]=%0d expected %0d", tag, o, xbar_sel[o*PW +: PW], ei);
        end
    endtask

    task automatic zero_in();
        ns_req = '0; sp_req = '0; va_ok = '0; ns_port = '0; sp_port = '0; credit_ok = '1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        zero_in();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // one cycle: apply at negedge, compare 1 ns later
    task automatic cyc(input logic [P*V-1:0] a_ns, input logic [P*V*PW-1:0] a_nsp,
                       input logic [P*V-1:0] a_sp, input logic [P*V*PW-1:0] a_spp,
                       input logic [P*V-1:0] a_va, input logic [P-1:0] a_cr, input string tag);
        @(negedge clk);
        ns_req = a_ns; ns_port = a_nsp; sp_req = a_sp; sp_port = a_spp;
        va_ok = a_va; credit_ok = a_cr;
        #1;
        cmp_model(tag);
    endtask

    function automatic logic [31:0] lfsr(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] s1, s2;
        do_reset();

        // R1: idle after reset
        cyc('0, '0, '0, '0, '0, 3'b111, "R1 idle");
        hand("R1 idle after reset", 3'b000, 6'b000000);

        // R3: lone request from input 1 VC 1 to output 2 (field bits (1*2+1)*2 = 6)
        do_reset();
        cyc(6'b001000, 12'b0000_1000_0000, '0, '0, '0, 3'b111, "R3 lone");
        hand("R3 lone grant", 3'b100, 6'b001000);
        hand_sel("R3 select", 2, 1);

        // R6: input 0 VC0 -> out0 (no credit), VC1 -> out1
        do_reset();
        cyc(6'b000011, 12'b0000_0000_0100, '0, '0, '0, 3'b110, "R6 credit");
        hand("R6 credit mask", 3'b010, 6'b000010);
        hand_sel("R6 select", 1, 0);

        // R7: speculative in0 VC0 and in2 VC0 both -> out1; in0 fails VC allocation
        do_reset();
        cyc('0, '0, 6'b010001, 12'b0001_0000_0001, 6'b010000, 3'b111, "R7 cancel");
        hand("R7 wasted slot", 3'b000, 6'b000000);

        // R9: pointers held; in0 VC0 and VC1 speculative -> out0, both succeed: VC0 still first
        cyc('0, '0, 6'b000011, '0, 6'b000011, 3'b111, "R9 hold");
        hand("R9 cancelled keeps priority", 3'b001, 6'b000001);

        // R8: output-side conflict, ns in0 VC0 vs sp in1 VC0 on out0
        do_reset();
        cyc(6'b000001, '0, 6'b000100, '0, 6'b111111, 3'b111, "R8 output");
        hand("R8 output conflict", 3'b001, 6'b000001);
        hand_sel("R8 select", 0, 0);

        // R8: input-side conflict, ns in0 VC0 -> out0, sp in0 VC1 -> out1
        do_reset();
        cyc(6'b000001, '0, 6'b000010, 12'b0000_0000_0100, 6'b111111, 3'b111, "R8 input");
        hand("R8 input conflict", 3'b001, 6'b000001);

        // R5: inputs 0 and 2 contend for out0, alternating
        do_reset();
        cyc(6'b010001, '0, '0, '0, '0, 3'b111, "R5 first");
        hand("R5 first winner", 3'b001, 6'b000001);
        cyc(6'b010001, '0, '0, '0, '0, 3'b111, "R5 second");
        hand("R5 rotated winner", 3'b001, 6'b010000);

        // R4: both VCs of input 1 to out2, alternating
        do_reset();
        cyc(6'b001100, 12'b0000_1010_0000, '0, '0, '0, 3'b111, "R4 first");
        hand("R4 first VC", 3'b100, 6'b000100);
        cyc(6'b001100, 12'b0000_1010_0000, '0, '0, '0, 3'b111, "R4 second");
        hand("R4 rotated VC", 3'b100, 6'b001000);

        // R2 R3 R4 R5 R6 R7 R8 R9: sweep over request mixes against the model
        do_reset();
        s1 = 32'h1d87_2a53;
        s2 = 32'h6b3c_9e01;
        for (int n = 0; n < 6000; n++) begin
            logic [P*V-1:0]    a_ns, a_sp;
            logic [P*V*PW-1:0] a_nsp, a_spp;
            for (int b = 0; b < 7; b++) begin s1 = lfsr(s1); s2 = lfsr(s2); end
            a_ns = s1[5:0] & s2[5:0];
            a_sp = s1[11:6] & ~a_ns;
            for (int k = 0; k < P*V; k++) begin
                a_nsp[k*PW +: PW] = PW'((s1[12+2*k +: 2] + s2[2*k +: 2]) % 3);
                a_spp[k*PW +: PW] = PW'((s2[12+2*k +: 2] + s1[2*k +: 2]) % 3);
            end
            cyc(a_ns, a_nsp, a_sp, a_spp, s2[29:24] | s1[29:24],
                s2[31] ? s1[26:24] : 3'b111, "R2 sweep");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule